// File: doc/BRIEF.md
# Three-Bank Cascaded Interrupt Controller

The controller gathers 96 level-sensitive request lines into three 32-bit banks and reports one winning request to the processor. Each bank has a read-only status word that mirrors its request lines and a primary enable word. A second set of three enable words feeds a secondary processor output that uses the same status words.

Two bank bits are cascade points rather than ordinary sources. Bit 8 of bank 0 carries the summary of a 32-bit software-interrupt word and its own enable word. Bit 4 of bank 1 carries an external GPIO summary line. While a cascade bit is pending, the controller reports the sub-source it stands for ahead of the other bits of that bank. The winner is reported as a valid flag, a class code and a 7-bit source index, all registered.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, every primary enable, secondary enable, software word and software enable reads 0, and irq_valid_o, irq_class_o, irq_id_o, cpu_irq_o and cpu_irq2_o are 0.
- R2: Source n sits in bank n/32 at bit n%32, and status words are read at addresses 0, 1 and 2 for banks 0, 1 and 2. Bank 0 bit 8 reads the software summary and bank 1 bit 4 reads gpio_irq_i. req_i[8] and req_i[36] are ignored.
- R3: A bank bit is pending only when its status bit and its primary enable bit are both 1. Primary enables for banks 0..2 are at addresses 3..5.
- R4: Bank 0 wins over bank 1, and bank 1 wins over bank 2. Inside a bank, the lowest pending bit wins. The reported main index is 32*bank+bit.
- R5: The software word (address 9, write 1 sets and 0 clears) ANDed with its enable word (address 10) drives bank 0 bit 8. When that bit is pending, the lowest active software bit is reported with the software class, ahead of every other bank 0 bit.
- R6: gpio_irq_i drives bank 1 bit 4. When that bit is pending and bank 0 has nothing pending, the GPIO class with index 36 is reported ahead of the other bank 1 bits.
- R7: The main class never reports index 8 or index 36. An enabled cascade bit whose sub-source is idle causes no report.
- R8: A request stays reported while its input stays high, and it is withdrawn after the input falls.
- R9: Enable words and the software words read back exactly what was last written. A write to a status address changes nothing.
- R10: cpu_irq2_o is 1 exactly when any status bit is set together with its secondary enable bit (addresses 6..8), whatever the primary enables hold.
- R11: The outputs change on the first rising clock edge after an input or register change. cpu_irq_o equals irq_valid_o.
- R12: The class code is 0 for main, 1 for software and 2 for GPIO. With nothing pending, the class and the index both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 96 | Level-sensitive main request lines |
| gpio_irq_i | input | 1 | GPIO summary request |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_valid_o | output | 1 | A request is being reported |
| irq_class_o | output | 2 | Class of the reported request |
| irq_id_o | output | 7 | Index of the reported request |
| cpu_irq_o | output | 1 | Primary processor interrupt |
| cpu_irq2_o | output | 1 | Secondary processor interrupt |

## Verification
The key collision is a cascade bit and a lower-numbered ordinary bit of the same bank pending in the same cycle. The bench provokes it by holding main source 0 enabled while software bit 7 becomes active, and by holding source 32 enabled while the GPIO line rises. It then checks that the software class and the GPIO class are reported, and that the main source returns once the cascade source is cleared. A second collision pairs the GPIO cascade with a pending bank 0 bit, and bank order must still win there.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  typedef enum logic [1:0] {
    CLS_MAIN = 2'd0,
    CLS_SW   = 2'd1,
    CLS_GPIO = 2'd2
  } irq_class_e;
endpackage

// File: rtl/cirq_ffs.sv
module cirq_ffs #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cirq_regs.sv
module cirq_regs #(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned SW_BANK   = 0,
  parameter int unsigned SW_BIT    = 8,
  parameter int unsigned GPIO_BANK = 1,
  parameter int unsigned GPIO_BIT  = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [BANK_W-1:0]                  wdata_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]   req_i,
  input  logic                               gpio_irq_i,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   status_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   en_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   en2_o,
  output logic [BANK_W-1:0]                  sw_act_o,
  output logic [BANK_W-1:0]                  rdata_o
);
  localparam int unsigned EN_BASE  = NUM_BANKS;
  localparam int unsigned EN2_BASE = 2 * NUM_BANKS;
  localparam int unsigned SW_ADDR  = 3 * NUM_BANKS;
  localparam int unsigned SWEN_ADR = 3 * NUM_BANKS + 1;

  logic [NUM_BANKS-1:0][BANK_W-1:0] en_q, en2_q;
  logic [BANK_W-1:0] sw_q, sw_en_q;

  assign sw_act_o = sw_q & sw_en_q;
  assign en_o     = en_q;
  assign en2_o    = en2_q;

  // status is a live mirror; cascade positions carry the sub-source summaries
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stat
    always_comb begin
      status_o[b] = req_i[b];
      if (b == SW_BANK)   status_o[b][SW_BIT]   = |sw_act_o;
      if (b == GPIO_BANK) status_o[b][GPIO_BIT] = gpio_irq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      en2_q   <= '0;
      sw_q    <= '0;
      sw_en_q <= '0;
    end else if (wr_en_i) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (addr_i == ADDR_W'(EN_BASE + b))  en_q[b]  <= wdata_i;
        if (addr_i == ADDR_W'(EN2_BASE + b)) en2_q[b] <= wdata_i;
      end
      if (addr_i == ADDR_W'(SW_ADDR))  sw_q    <= wdata_i;
      if (addr_i == ADDR_W'(SWEN_ADR)) sw_en_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(b))            rdata_o = status_o[b];
      if (addr_i == ADDR_W'(EN_BASE + b))  rdata_o = en_q[b];
      if (addr_i == ADDR_W'(EN2_BASE + b)) rdata_o = en2_q[b];
    end
    if (addr_i == ADDR_W'(SW_ADDR))  rdata_o = sw_q;
    if (addr_i == ADDR_W'(SWEN_ADR)) rdata_o = sw_en_q;
  end

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_W'(EN_BASE) |=> en_q[0] == $past(wdata_i)); // R9
  AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(SW_ADDR)) |=> $stable(sw_q)); // R9
endmodule

// File: rtl/cirq_resolve.sv
module cirq_resolve
  import cirq_pkg::*;
#(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned SW_BANK   = 0,
  parameter int unsigned SW_BIT    = 8,
  parameter int unsigned GPIO_BANK = 1,
  parameter int unsigned GPIO_BIT  = 4,
  parameter int unsigned ID_W      = 7
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] status_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] en_i,
  input  logic [BANK_W-1:0]                sw_act_i,
  output logic                             valid_o,
  output irq_class_e                       class_o,
  output logic [ID_W-1:0]                  id_o
);
  localparam int unsigned IW = (BANK_W > 1) ? $clog2(BANK_W) : 1;

  logic [NUM_BANKS-1:0][BANK_W-1:0] pend, ord;
  logic [NUM_BANKS-1:0]             found;
  logic [IW-1:0]                    idx [NUM_BANKS];
  logic                             sw_found;
  logic [IW-1:0]                    sw_idx;
  logic [NUM_BANKS:0]               any_below;

  assign any_below[0] = 1'b0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign pend[b] = status_i[b] & en_i[b];
    // cascade bits are dropped before the ordinary search
    always_comb begin
      ord[b] = pend[b];
      if (b == SW_BANK)   ord[b][SW_BIT]   = 1'b0;
      if (b == GPIO_BANK) ord[b][GPIO_BIT] = 1'b0;
    end
    assign any_below[b+1] = any_below[b] | (|pend[b]);
    cirq_ffs #(.W(BANK_W)) i_ffs (
      .vec_i  (ord[b]),
      .found_o(found[b]),
      .idx_o  (idx[b])
    );
  end

  cirq_ffs #(.W(BANK_W)) i_sw_ffs (
    .vec_i  (sw_act_i),
    .found_o(sw_found),
    .idx_o  (sw_idx)
  );

  always_comb begin
    valid_o = 1'b0;
    class_o = CLS_MAIN;
    id_o    = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (b == int'(SW_BANK) && pend[b][SW_BIT]) begin
        valid_o = sw_found;
        class_o = CLS_SW;
        id_o    = ID_W'(sw_idx);
      end else if (b == int'(GPIO_BANK) && pend[b][GPIO_BIT]) begin
        valid_o = 1'b1;
        class_o = CLS_GPIO;
        id_o    = ID_W'(b * BANK_W + GPIO_BIT);
      end else if (found[b]) begin
        valid_o = 1'b1;
        class_o = CLS_MAIN;
        id_o    = ID_W'(b * int'(BANK_W) + int'(idx[b]));
      end
    end
  end

  AST_SW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[SW_BANK][SW_BIT] && !any_below[SW_BANK] |-> valid_o && class_o == CLS_SW); // R5
  AST_GPIO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[GPIO_BANK][GPIO_BIT] && !any_below[GPIO_BANK] |-> valid_o && class_o == CLS_GPIO); // R6
  AST_BANK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend[0]) |-> valid_o && id_o < ID_W'(BANK_W)); // R4
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cirq_pkg::*;
#(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned SW_BANK   = 0,
  parameter int unsigned SW_BIT    = 8,
  parameter int unsigned GPIO_BANK = 1,
  parameter int unsigned GPIO_BIT  = 4,
  localparam int unsigned NUM_SRC  = BANK_W * NUM_BANKS,
  localparam int unsigned ID_W     = $clog2(NUM_SRC),
  localparam int unsigned ADDR_W   = $clog2(3 * NUM_BANKS + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               gpio_irq_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BANK_W-1:0]  wdata_i,
  output logic [BANK_W-1:0]  rdata_o,
  output logic               irq_valid_o,
  output logic [1:0]         irq_class_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic               cpu_irq_o,
  output logic               cpu_irq2_o
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] req_b, status, en, en2;
  logic [BANK_W-1:0] sw_act;
  logic              res_valid, sec_any;
  irq_class_e        res_class;
  logic [ID_W-1:0]   res_id;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_split
    assign req_b[b] = req_i[b*BANK_W +: BANK_W];
  end

  cirq_regs #(
    .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .SW_BANK(SW_BANK), .SW_BIT(SW_BIT),
    .GPIO_BANK(GPIO_BANK), .GPIO_BIT(GPIO_BIT), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .req_i     (req_b),
    .gpio_irq_i(gpio_irq_i),
    .status_o  (status),
    .en_o      (en),
    .en2_o     (en2),
    .sw_act_o  (sw_act),
    .rdata_o   (rdata_o)
  );

  cirq_resolve #(
    .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .SW_BANK(SW_BANK), .SW_BIT(SW_BIT),
    .GPIO_BANK(GPIO_BANK), .GPIO_BIT(GPIO_BIT), .ID_W(ID_W)
  ) i_resolve (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status),
    .en_i    (en),
    .sw_act_i(sw_act),
    .valid_o (res_valid),
    .class_o (res_class),
    .id_o    (res_id)
  );

  assign sec_any = |(status & en2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o <= 1'b0;
      irq_class_o <= 2'd0;
      irq_id_o    <= '0;
      cpu_irq_o   <= 1'b0;
      cpu_irq2_o  <= 1'b0;
    end else begin
      irq_valid_o <= res_valid;
      irq_class_o <= res_valid ? 2'(res_class) : 2'd0;
      irq_id_o    <= res_valid ? res_id : '0;
      cpu_irq_o   <= res_valid;
      cpu_irq2_o  <= sec_any;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_valid_o == $past(res_valid)); // R11
  AST_NO_CASCADE_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && irq_class_o == 2'(CLS_MAIN) |->
      irq_id_o != ID_W'(SW_BANK * BANK_W + SW_BIT) &&
      irq_id_o != ID_W'(GPIO_BANK * BANK_W + GPIO_BIT)); // R7
  AST_SEC_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cpu_irq2_o == $past(sec_any)); // R10
endmodule

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  localparam logic [3:0] A_ST0 = 4'd0, A_ST1 = 4'd1, A_EN0 = 4'd3, A_EN1 = 4'd4,
                         A_EN2 = 4'd5, A_SE0 = 4'd6, A_SE1 = 4'd7, A_SE2 = 4'd8,
                         A_SW = 4'd9, A_SWEN = 4'd10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] req = '0;
  logic        gpio = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        valid, cpu, cpu2;
  logic [1:0]  cls;
  logic [6:0]  id;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gpio_irq_i(gpio),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_valid_o(valid), .irq_class_o(cls), .irq_id_o(id),
    .cpu_irq_o(cpu), .cpu_irq2_o(cpu2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input logic v, input logic [1:0] c, input logic [6:0] i);
    chk({tag, " valid"}, 32'(valid), 32'(v));
    chk({tag, " class"}, 32'(cls), 32'(c));
    chk({tag, " id"}, 32'(id), 32'(i));
    chk({tag, " cpu R11"}, 32'(cpu), 32'(v));
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic clean();
    req = '0; gpio = 1'b0;
    for (int a = 3; a <= 10; a++) wr(4'(a), 32'h0);
    tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 3; a <= 10; a++) begin
      rd(4'(a), d);
      chk("R1 reg zero", d, 32'h0);
    end
    chk_irq("R1 outputs", 1'b0, 2'd0, 7'd0);
    chk("R1 cpu2", 32'(cpu2), 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_EN1, 32'hA5A5_0F0F); rd(A_EN1, d); chk("R9 en1 readback", d, 32'hA5A5_0F0F);
    wr(A_SE2, 32'h1234_5678); rd(A_SE2, d); chk("R9 en2 readback", d, 32'h1234_5678);
    wr(A_SWEN, 32'h8000_0001); rd(A_SWEN, d); chk("R9 swen readback", d, 32'h8000_0001);
    wr(A_ST0, 32'hFFFF_FFFF); rd(A_ST0, d); chk("R9 status not writable", d, 32'h0);
    req[0] = 1'b1; req[8] = 1'b1; req[33] = 1'b1; req[36] = 1'b1; gpio = 1'b1;
    rd(A_ST0, d); chk("R2 status bank0", d, 32'h0000_0001);
    rd(A_ST1, d); chk("R2 status bank1", d, 32'h0000_0012);
    clean();
  endtask

  task automatic t_pending();
    req[5] = 1'b1; tick();
    chk_irq("R3 no enable", 1'b0, 2'd0, 7'd0);
    wr(A_EN0, 32'h0000_0020); tick();
    chk_irq("R3 enabled", 1'b1, 2'd0, 7'd5);
    clean();
  endtask

  task automatic t_priority();
    wr(A_EN0, '1); wr(A_EN1, '1); wr(A_EN2, '1);
    req[40] = 1'b1; req[70] = 1'b1; tick();
    chk_irq("R4 bank1 over bank2", 1'b1, 2'd0, 7'd40);
    wr(A_EN1, 32'h0); tick();
    chk_irq("R4 bank2 alone", 1'b1, 2'd0, 7'd70);
    req[12] = 1'b1; req[9] = 1'b1; tick();
    chk_irq("R4 lowest in bank0", 1'b1, 2'd0, 7'd9);
    clean();
  endtask

  task automatic t_level();
    wr(A_EN2, 32'h0000_0008);
    req[67] = 1'b1; #1;
    chk_irq("R11 not yet", 1'b0, 2'd0, 7'd0);
    tick();
    chk_irq("R11 one edge", 1'b1, 2'd0, 7'd67);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_irq("R8 held", 1'b1, 2'd0, 7'd67);
    end
    req[67] = 1'b0; tick();
    chk_irq("R8 withdrawn", 1'b0, 2'd0, 7'd0);
    clean();
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr(A_EN0, 32'h0000_0001); req[0] = 1'b1; tick();
    chk_irq("R5 main first", 1'b1, 2'd0, 7'd0);
    wr(A_SWEN, 32'h0000_0088); wr(A_SW, 32'h0000_0080); tick();
    chk_irq("R5 sw gated by bank enable", 1'b1, 2'd0, 7'd0);
    rd(A_ST0, d); chk("R5 summary status", d, 32'h0000_0101);
    wr(A_EN0, 32'h0000_0101); tick();
    chk_irq("R5 sw beats bit0", 1'b1, 2'd1, 7'd7);
    wr(A_SW, 32'h0000_00C8); tick();
    chk_irq("R5 lowest sw", 1'b1, 2'd1, 7'd3);
    wr(A_SW, 32'h0000_0040); tick();
    chk_irq("R5 sw not enabled", 1'b1, 2'd0, 7'd0);
    wr(A_SW, 32'h0); tick();
    chk_irq("R5 back to main", 1'b1, 2'd0, 7'd0);
    clean();
  endtask

  task automatic t_gpio();
    wr(A_EN1, 32'h0000_0011); req[32] = 1'b1; tick();
    chk_irq("R6 main bank1", 1'b1, 2'd0, 7'd32);
    gpio = 1'b1; tick();
    chk_irq("R6 gpio beats bit32", 1'b1, 2'd2, 7'd36);
    wr(A_EN0, 32'h0000_0002); req[1] = 1'b1; tick();
    chk_irq("R6 bank0 beats gpio", 1'b1, 2'd0, 7'd1);
    clean();
  endtask

  task automatic t_cascade_idle();
    wr(A_EN0, 32'h0000_0100); wr(A_EN1, 32'h0000_0010);
    req[8] = 1'b1; req[36] = 1'b1; tick();
    chk_irq("R7 idle cascades", 1'b0, 2'd0, 7'd0);
    clean();
  endtask

  task automatic t_secondary();
    wr(A_SE2, 32'h0000_0001); req[64] = 1'b1; tick();
    chk("R10 cpu2 set", 32'(cpu2), 32'h1);
    chk_irq("R10 primary quiet", 1'b0, 2'd0, 7'd0);
    wr(A_SE2, 32'h0); wr(A_SE0, 32'h0000_0100); tick();
    chk("R10 cpu2 cleared", 32'(cpu2), 32'h0);
    wr(A_SWEN, 32'h1); wr(A_SW, 32'h1); tick();
    chk("R10 sw via secondary", 32'(cpu2), 32'h1);
    chk_irq("R12 idle zero", 1'b0, 2'd0, 7'd0);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pending();
    t_priority();
    t_level();
    t_sw();
    t_gpio();
    t_cascade_idle();
    t_secondary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule